// File: doc/BRIEF.md
# Synchronous USB FIFO Writer

This block drains 32-bit words from a first-word-fall-through buffer into an external USB bridge that takes data over a synchronous parallel FIFO interface. The whole block runs on the bridge clock. The bridge pulls an active-low transmit-ready line low when it can accept data. After the block has seen ready low on enough consecutive rising edges, it pulls an active-low write strobe low and presents the head word of the buffer on the data bus.

While ready stays low and the buffer holds data, the block moves one word on every clock. A word counts as moved on an edge where both the strobe and ready are low. The buffer is popped on exactly those edges, so a word that was presented but not taken stays at the head of the buffer. The byte-enable bus is tied all ones, so every transfer carries a full word. A wrapping counter of moved words is brought out so that the traffic can be reconciled against what was pushed into the buffer.

Top module: `usb_fifo_writer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the write strobe `wr_n` is high, `src_pop` is low and `xfer_count` is zero.
- R2: Every bit of `byte_en` is 1 in every cycle.
- R3: `wr_n` is low only after `txe_n` has been sampled low on at least WAIT_CYC+1 consecutive rising edges. With WAIT_CYC=2, it falls right after the third such edge when the buffer holds data.
- R4: A rising edge with `txe_n` high restarts the wait. In the cycle after that edge, `wr_n` is high.
- R5: `wr_n` is high in every cycle in which `src_empty` is 1.
- R6: `src_pop` is 1 exactly in the cycles where `wr_n` and `txe_n` are both low, so the buffer is popped on each transfer edge and on no other edge.
- R7: The words moved are the pushed words in push order, and none is skipped or sent twice. While `wr_n` is low, `bus_data` shows the current buffer head.
- R8: While `txe_n` stays low and the buffer holds data, one word moves per clock. N buffered words leave in N consecutive cycles once the wait is over.
- R9: While `wr_n` is high, `bus_data` holds the last word transferred. It does not follow `src_data`.
- R10: `xfer_count` rises by one on each transfer edge and wraps modulo 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_data | input | DATA_W | Head word of the first-word-fall-through buffer |
| src_empty | input | 1 | Buffer holds no word |
| src_pop | output | 1 | Remove the head word at this edge |
| txe_n | input | 1 | Bridge ready to take data, active low |
| wr_n | output | 1 | Write strobe, active low |
| byte_en | output | DATA_W/8 | Byte enables, all ones |
| bus_data | output | DATA_W | Data bus to the bridge |
| xfer_count | output | CNT_W | Wrapping count of words transferred |

## Verification
The bench builds the block with DATA_W=32 and WAIT_CYC=2, and shrinks CNT_W to 6. The narrow counter means that roughly a hundred streamed words take `xfer_count` through its wrap, so the modulo behaviour is reached in a short run. The bench drives the ready line in bursts of one, two and several cycles. Single-cycle dips and gaps land on every phase of the two-cycle wait. They also exercise a strobe that is withdrawn while a word is being presented, and a buffer that runs dry in the middle of a ready period.

// File: rtl/ufw_pkg.sv
package ufw_pkg;

  // Next value of the ready-wait counter: cleared by a high ready line,
  // otherwise counts up and saturates at the limit.
  function automatic int wait_step(input int cur, input logic txe_n, input int lim);
    if (txe_n) return 0;
    if (cur >= lim) return lim;
    return cur + 1;
  endfunction

  // The wait is over when ready is low now and the limit was reached.
  function automatic logic wait_met(input int cur, input logic txe_n, input int lim);
    return (!txe_n) && (cur >= lim);
  endfunction

  // A word moves when the strobe is driven and the bridge is ready.
  function automatic logic xfer_edge(input logic drive, input logic txe_n);
    return drive && !txe_n;
  endfunction

endpackage

// File: rtl/ufw_ready_wait.sv
module ufw_ready_wait #(
  parameter int WAIT_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic txe_n,
  output logic ready_ok
);
  import ufw_pkg::*;

  localparam int CW = $clog2(WAIT_CYC + 1) + 1;

  logic [CW-1:0] wait_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_q <= '0;
    else        wait_q <= CW'(wait_step(int'(wait_q), txe_n, WAIT_CYC));
  end

  assign ready_ok = wait_met(int'(wait_q), txe_n, WAIT_CYC);
endmodule

// File: rtl/ufw_strobe_ctrl.sv
module ufw_strobe_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic ready_ok,
  input  logic src_empty,
  output logic drive,
  output logic wr_n
);
  logic arm_q;

  // Armed for the next cycle when the wait is over and data is present.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_q <= 1'b0;
    else        arm_q <= ready_ok && !src_empty;
  end

  // An empty buffer withdraws the strobe at once, so no stale word is sent.
  assign drive = arm_q && !src_empty;
  assign wr_n  = !drive;
endmodule

// File: rtl/ufw_data_hold.sv
module ufw_data_hold #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drive,
  input  logic              accept,
  input  logic [DATA_W-1:0] src_data,
  output logic [DATA_W-1:0] bus_data
);
  logic [DATA_W-1:0] last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      last_q <= '0;
    else if (accept) last_q <= src_data;
  end

  assign bus_data = drive ? src_data : last_q;
endmodule

// File: rtl/ufw_xfer_count.sv
module ufw_xfer_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (accept) count <= count + CNT_W'(1);
  end
endmodule

// File: rtl/usb_fifo_writer.sv
module usb_fifo_writer #(
  parameter int DATA_W   = 32,
  parameter int WAIT_CYC = 2,
  parameter int CNT_W    = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DATA_W-1:0]    src_data,
  input  logic                 src_empty,
  output logic                 src_pop,
  input  logic                 txe_n,
  output logic                 wr_n,
  output logic [DATA_W/8-1:0]  byte_en,
  output logic [DATA_W-1:0]    bus_data,
  output logic [CNT_W-1:0]     xfer_count
);
  import ufw_pkg::*;

  localparam int BE_W = DATA_W / 8;

  logic ready_ok;
  logic drive;
  logic accept;

  ufw_ready_wait #(.WAIT_CYC(WAIT_CYC)) u_wait (
    .clk(clk), .rst_n(rst_n), .txe_n(txe_n), .ready_ok(ready_ok)
  );

  ufw_strobe_ctrl u_strobe (
    .clk(clk), .rst_n(rst_n), .ready_ok(ready_ok), .src_empty(src_empty),
    .drive(drive), .wr_n(wr_n)
  );

  assign accept = xfer_edge(drive, txe_n);
  assign src_pop = accept;

  ufw_data_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .drive(drive), .accept(accept),
    .src_data(src_data), .bus_data(bus_data)
  );

  ufw_xfer_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .accept(accept), .count(xfer_count)
  );

  assign byte_en = {BE_W{1'b1}};
endmodule

// File: rtl/ufw_checker.sv
module ufw_checker #(
  parameter int DATA_W   = 32,
  parameter int WAIT_CYC = 2,
  parameter int CNT_W    = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              txe_n,
  input logic              wr_n,
  input logic              src_empty,
  input logic              src_pop,
  input logic [DATA_W-1:0] bus_data,
  input logic [CNT_W-1:0]  xfer_count
);
  localparam int RW = $clog2(WAIT_CYC + 2) + 1;

  // Independent run length of ready-low edges, saturating.
  logic [RW-1:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          run_q <= '0;
    else if (txe_n)                      run_q <= '0;
    else if (int'(run_q) <= WAIT_CYC)    run_q <= run_q + RW'(1);
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |-> (wr_n && !src_pop && xfer_count == '0));

  // R3
  wait_met_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (int'(run_q) == WAIT_CYC + 1));

  // R4
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txe_n |=> wr_n);

  // R5
  empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_empty |-> wr_n);

  // R6
  pop_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_pop == (!wr_n && !txe_n));

  // R9
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_n |=> (!wr_n || $stable(bus_data)));

  // R10
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_pop |=> (xfer_count == $past(xfer_count) + CNT_W'(1)));

  // R10
  count_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !src_pop |=> $stable(xfer_count));
endmodule

bind usb_fifo_writer ufw_checker #(
  .DATA_W(DATA_W), .WAIT_CYC(WAIT_CYC), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .txe_n(txe_n), .wr_n(wr_n),
  .src_empty(src_empty), .src_pop(src_pop), .bus_data(bus_data),
  .xfer_count(xfer_count)
);

// File: tb/usb_fifo_writer_test.sv
`timescale 1ns/1ps
module usb_fifo_writer_test;
  localparam int DW = 32;
  localparam int WC = 2;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] src_data = '0;
  logic          src_empty = 1'b1;
  logic          src_pop;
  logic          txe_n = 1'b1;
  logic          wr_n;
  logic [3:0]    byte_en;
  logic [DW-1:0] bus_data;
  logic [CW-1:0] xfer_count;

  usb_fifo_writer #(.DATA_W(DW), .WAIT_CYC(WC), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .src_data(src_data), .src_empty(src_empty),
    .src_pop(src_pop), .txe_n(txe_n), .wr_n(wr_n), .byte_en(byte_en),
    .bus_data(bus_data), .xfer_count(xfer_count)
  );

  always #2 clk = ~clk;

  int total = 0;
  int bad = 0;
  logic [DW-1:0] buf_q[$];   // model of the source buffer
  logic [DW-1:0] exp_q[$];   // scoreboard of expected words
  int low_run = 0;
  int sent = 0;
  int pushed = 0;
  logic [DW-1:0] last_sent = '0;
  bit any_sent = 0;
  bit arm_first = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic push_word(input logic [DW-1:0] w);
    buf_q.push_back(w);
    exp_q.push_back(w);
    pushed++;
  endtask

  // One clock: update bench state for the edge just passed, drive, monitor.
  task automatic step(input logic txe);
    logic [DW-1:0] e;
    @(negedge clk);
    low_run = (!rst_n || txe_n) ? 0 : low_run + 1;
    txe_n = txe;
    src_empty = (buf_q.size() == 0);
    src_data = src_empty ? 32'hDEAD_BEEF : buf_q[0];
    #1;
    if (rst_n) begin
      chk(byte_en == 4'hF, "R2 byte_en", byte_en, 4'hF);
      chk(wr_n || low_run >= WC + 1, "R3 early strobe", low_run, WC + 1);
      if (low_run == 0) chk(wr_n, "R4 strobe after ready high", wr_n, 1);
      if (src_empty) chk(wr_n, "R5 strobe while empty", wr_n, 1);
      chk(src_pop == (!wr_n && !txe_n), "R6 pop", src_pop, !wr_n && !txe_n);
      chk(xfer_count == CW'(sent), "R10 count", xfer_count, CW'(sent));
      if (wr_n && any_sent) chk(bus_data == last_sent, "R9 hold", bus_data, last_sent);
      if (arm_first && !wr_n) begin
        chk(low_run == WC + 1, "R3 first strobe", low_run, WC + 1);
        arm_first = 0;
      end
      if (src_pop) begin
        if (exp_q.size() == 0) chk(0, "R7 extra word", bus_data, 0);
        else begin
          e = exp_q.pop_front();
          chk(bus_data == e, "R7 order", bus_data, e);
        end
        void'(buf_q.pop_front());
        last_sent = bus_data;
        any_sent = 1;
        sent++;
      end
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int c0;
    for (int i = 0; i < 3; i++) step(1'b1);
    #1;
    chk(wr_n && !src_pop && xfer_count == 0, "R1 in reset", {wr_n, src_pop, xfer_count}, 8'h80);
    rst_n = 1'b1;
    step(1'b1);
    chk(wr_n && !src_pop && xfer_count == 0, "R1 after reset", {wr_n, src_pop, xfer_count}, 8'h80);

    // R8: eight words, three wait edges then eight back-to-back transfers
    for (int i = 0; i < 8; i++) push_word(32'hA500_0000 + i);
    arm_first = 1;
    c0 = sent;
    for (int i = 0; i < 12; i++) step(1'b0);
    chk(sent - c0 == 8, "R8 burst of eight", sent - c0, 8);
    chk(xfer_count == CW'(8), "R8 count after burst", xfer_count, 8);
    chk(wr_n, "R5 drained", wr_n, 1);

    // R4: ready toggling with short dips at every phase of the wait
    for (int i = 0; i < 20; i++) push_word(32'h5A00_0100 + i);
    step(1'b1);
    arm_first = 1;
    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < r; i++) step(1'b0);
      step(1'b1);
      if (r < 3) chk(xfer_count == CW'(8), "R4 no transfer in short bursts", xfer_count, 8);
    end
    for (int i = 0; i < 30; i++) step(1'b0);
    chk(exp_q.size() == 0, "R7 toggle drain", exp_q.size(), 0);

    // R5: trickle data with ready held low
    for (int i = 0; i < 10; i++) begin
      push_word(32'hC0DE_0000 + i);
      step(1'b0); step(1'b0); step(1'b0);
    end
    step(1'b0);
    chk(exp_q.size() == 0, "R5 trickle drained", exp_q.size(), 0);

    // R10: long stream that wraps the 6-bit counter
    for (int i = 0; i < 60; i++) push_word(32'h1234_0000 + i * 7);
    step(1'b1);
    for (int i = 0; i < 70; i++) step(1'b0);
    chk(sent == pushed, "R7 all words sent", sent, pushed);
    chk(xfer_count == CW'(pushed), "R10 wrapped count", xfer_count, CW'(pushed));
    chk(pushed > 64, "R10 wrap reached", pushed, 65);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule